// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a single-port data cache placed between one processor port and a 1 KB main memory. It holds eight lines of eight bytes. A byte address of ten bits is split into a 4-bit tag (bits 9:6), a 3-bit line index (bits 5:3) and a 3-bit byte offset (bits 2:0). For each access, one index reads a tag entry and a data line together. The access hits when the entry is valid and its stored tag equals the address tag. A miss brings in the whole line from memory and rewrites the tag entry.

An elaboration-time parameter selects how writes behave. The three choices are write-through without allocation, write-through with allocation, and write-back with a per-line dirty flag. Line fills, victim write-backs and write-through stores each move over a memory port as one request, which memory answers with a single acknowledge. A line transfer carries the whole 64-bit line. Byte lane k of the line sits on bits 8k+7:8k.

The processor holds `cpu_req` and its address and data steady until it sees `cpu_ready` high. The access completes on the rising edge where both are high. On a read, `cpu_rdata` is valid in that same cycle.

Top module: `dmc_cache_top`

## Requirements
- R1: After reset every line is invalid. `cpu_ready` and `mem_req` are low with no request pending, and the first access to any address misses.
- R2: The memory port line address is address bits 9:3, and the victim line address is the stored tag followed by the index. `mem_be` bit k enables byte lane k.
- R3: A read hit completes in the cycle the request is presented: `cpu_ready` is high with no memory transaction, and `cpu_rdata` holds the addressed byte.
- R4: A read miss to an invalid line, or to a clean line in write-back mode, makes exactly one memory read of the requested line. The following access to that line hits.
- R5: Two lines with equal index and different tag evict each other, so reading the older one again misses and refetches it.
- R6: In both write-through modes, a write hit updates the cached byte and sends one memory write whose `mem_be` is one-hot at the byte offset.
- R7: In write-through non-allocate mode, a write miss sends only the one-byte memory write and leaves the cached line and its tag unchanged.
- R8: In write-through allocate mode, a write miss first reads the line from memory and then performs the one-byte write as a hit.
- R9: In write-back mode, a write hit makes no memory transaction, leaves memory unchanged and marks the line dirty.
- R10: In write-back mode, a miss on a dirty line first writes the whole victim line back (`mem_be` all ones), then reads the new line, which is left clean. A clean victim is not written back.
- R11: `cpu_ready` stays low in every cycle in which `mem_req` is high.
- R12: Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until the cycle in which `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 10 | Byte address (tag, index, offset) |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Byte read, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access completes on this rising edge |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = line read |
| mem_addr | output | 7 | Line address in memory |
| mem_be | output | 8 | Byte-lane enables for a write |
| mem_wdata | output | 64 | Write data, lane k on bits 8k+7:8k |
| mem_rdata | input | 64 | Line returned with mem_ack on a read |
| mem_ack | input | 1 | One-cycle completion of the current transaction |

## Verification
A hit that needs no memory traffic must show `cpu_ready` as soon as the request is driven, so the bench samples ready one time step after driving it and expects zero waited cycles. An access that needs memory finishes only after every acknowledge has been sampled by a rising edge. Write-through stores add one more cycle after their acknowledge, and filled lines add one lookup cycle back in idle. The bench therefore waits at falling edges for ready, without fixing a count. It then compares the transactions logged by its memory model, the read byte and the memory image against a behavioural model. Acknowledge delays of zero to three cycles exercise the holding rules, and these are checked at every falling edge.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache: write-policy selector and
// controller state encoding. Assumes no other package defines these names.
package dmc_pkg;

    typedef enum logic [1:0] {
        WP_THRU_NOALLOC = 2'd0,
        WP_THRU_ALLOC   = 2'd1,
        WP_BACK         = 2'd2
    } wpol_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_EVICT = 3'd1,
        S_FILL  = 3'd2,
        S_THRU  = 3'd3,
        S_DONE  = 3'd4
    } cst_e;

endpackage

// File: rtl/dmc_tag_store.sv
// Tag directory: one valid flag, one dirty flag and one tag per line.
// Lookup is combinational on the index; hit compares the stored tag with
// the address tag. Assumes fill and dirty-set never need to happen together.
module dmc_tag_store #(
    parameter int TAG_W = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             fill_en,
    input  logic             dirty_set,
    output logic             hit,
    output logic             vld,
    output logic             dirty,
    output logic [TAG_W-1:0] tag_out
);
    localparam int NLINES = 1 << IDX_W;

    logic [NLINES-1:0] valid_q;
    logic [NLINES-1:0] dirty_q;
    logic [TAG_W-1:0]  tag_q [NLINES];

    // Status flags: cleared by reset, set by fill, dirty marked on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag array: rewritten with the new tag when a line is filled.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= tag_in;
        end
    end

    // Lookup: compare indexed entry against the address tag.
    always_comb begin
        vld     = valid_q[idx];
        dirty   = dirty_q[idx];
        tag_out = tag_q[idx];
        hit     = valid_q[idx] && (tag_q[idx] == tag_in);
    end

    // R9: the controller only marks a line dirty when that line hits.
    a_r9_dirty_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_set |-> hit);

    // R10: a dirty flag never sits on an invalid line.
    a_r10_dirty_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);

endmodule

// File: rtl/dmc_data_store.sv
// Line storage: NLINES lines of LINE_BYTES bytes. A fill writes a whole
// line; a processor write updates one byte lane. Read is combinational.
// Assumes fill and byte write are never requested in the same cycle.
module dmc_data_store #(
    parameter int IDX_W      = 3,
    parameter int LINE_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    fill_en,
    input  logic [LINE_BYTES*8-1:0] fill_line,
    input  logic [LINE_BYTES-1:0]   wr_be,
    input  logic [7:0]              wr_byte,
    output logic [LINE_BYTES*8-1:0] rd_line
);
    localparam int NLINES = 1 << IDX_W;
    localparam int LINE_W = LINE_BYTES * 8;

    logic [LINE_W-1:0] line_q [NLINES];

    // Array update: whole-line fill, else enabled byte lanes.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            line_q[idx] <= fill_line;
        end else begin
            for (int k = 0; k < LINE_BYTES; k++) begin
                if (wr_be[k]) begin
                    line_q[idx][k*8 +: 8] <= wr_byte;
                end
            end
        end
    end

    // Read port: the indexed line.
    assign rd_line = line_q[idx];

    // R6: a processor write touches at most one byte lane.
    a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_be));

    // R8: line fill and byte write are kept in separate cycles.
    a_r8_fill_alone: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (wr_be == '0));

endmodule

// File: rtl/dmc_ctrl.sv
// Cache sequencer. From idle it either completes the access at once or
// runs victim write-back, line fill or a write-through store. The policy
// parameter picks the write behaviour. Assumes the processor holds its
// request fields steady until it is accepted.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter wpol_e POLICY = WP_BACK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic hit,
    input  logic vld,
    input  logic dirty,
    input  logic mem_ack,
    output logic cpu_ready,
    output logic mem_req,
    output logic mem_we,
    output logic evict_sel,
    output logic fill_en,
    output logic commit_wr,
    output logic dirty_set
);
    localparam bit IS_WB      = (POLICY == WP_BACK);
    localparam bit IS_NOALLOC = (POLICY == WP_THRU_NOALLOC);

    cst_e state_q, state_d;

    // Next-state selection for each phase of an access.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        if (cpu_we && !IS_WB) state_d = S_THRU;
                    end else if (cpu_we && IS_NOALLOC) begin
                        state_d = S_THRU;
                    end else if (IS_WB && vld && dirty) begin
                        state_d = S_EVICT;
                    end else begin
                        state_d = S_FILL;
                    end
                end
            end
            S_EVICT: if (mem_ack) state_d = S_FILL;
            S_FILL:  if (mem_ack) state_d = S_IDLE;
            S_THRU:  if (mem_ack) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the current state and lookup result.
    always_comb begin
        cpu_ready = ((state_q == S_IDLE) && cpu_req && hit && (!cpu_we || IS_WB))
                    || (state_q == S_DONE);
        mem_req   = (state_q == S_EVICT) || (state_q == S_FILL) || (state_q == S_THRU);
        mem_we    = (state_q == S_EVICT) || (state_q == S_THRU);
        evict_sel = (state_q == S_EVICT);
        fill_en   = (state_q == S_FILL) && mem_ack;
        commit_wr = cpu_ready && cpu_we && hit;
        dirty_set = commit_wr && IS_WB;
    end

    // R11: no completion while memory traffic is outstanding.
    a_r11_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R12: request and direction hold until acknowledged.
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

    // R10: an acknowledged write-back is always followed by the refill.
    a_r10_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_EVICT) && mem_ack) |=> (state_q == S_FILL));

    // R4: once a fill is acknowledged, the held address hits.
    a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_FILL) && mem_ack) |=> hit);

    generate
        if (IS_NOALLOC) begin : g_noalloc_chk
            // R7: without allocation, writes never cause a line fill.
            a_r7_no_write_fill: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == S_FILL) |-> !cpu_we);
        end
    endgenerate

endmodule

// File: rtl/dmc_cache_top.sv
// Direct-mapped cache top: splits the address, wires tag and data stores
// to the sequencer and forms the memory-port address, lanes and data.
// Assumes a memory that returns a full line with a one-cycle acknowledge.
module dmc_cache_top
    import dmc_pkg::*;
#(
    parameter int    TAG_W  = 4,
    parameter int    IDX_W  = 3,
    parameter int    OFF_W  = 3,
    parameter wpol_e POLICY = WP_BACK
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [TAG_W+IDX_W+OFF_W-1:0]  cpu_addr,
    input  logic [7:0]                    cpu_wdata,
    output logic [7:0]                    cpu_rdata,
    output logic                          cpu_ready,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [TAG_W+IDX_W-1:0]        mem_addr,
    output logic [(1<<OFF_W)-1:0]         mem_be,
    output logic [(1<<OFF_W)*8-1:0]       mem_wdata,
    input  logic [(1<<OFF_W)*8-1:0]       mem_rdata,
    input  logic                          mem_ack
);
    localparam int LINE_BYTES = 1 << OFF_W;
    localparam int LINE_W     = LINE_BYTES * 8;

    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;

    logic              hit, vld, dirty, evict_sel, fill_en, commit_wr, dirty_set;
    logic [TAG_W-1:0]  vic_tag;
    logic [LINE_W-1:0] rd_line;
    logic [LINE_BYTES-1:0] lane_sel;

    // Address fields.
    assign a_tag = cpu_addr[TAG_W+IDX_W+OFF_W-1 -: TAG_W];
    assign a_idx = cpu_addr[IDX_W+OFF_W-1 -: IDX_W];
    assign a_off = cpu_addr[OFF_W-1:0];

    // One-hot byte-lane select from the offset, one comparator per lane.
    generate
        for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
            assign lane_sel[k] = (a_off == OFF_W'(k));
        end
    endgenerate

    dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(a_idx), .tag_in(a_tag),
        .fill_en(fill_en), .dirty_set(dirty_set),
        .hit(hit), .vld(vld), .dirty(dirty), .tag_out(vic_tag)
    );

    dmc_data_store #(.IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES)) u_data (
        .clk(clk), .rst_n(rst_n), .idx(a_idx),
        .fill_en(fill_en), .fill_line(mem_rdata),
        .wr_be(commit_wr ? lane_sel : '0), .wr_byte(cpu_wdata),
        .rd_line(rd_line)
    );

    dmc_ctrl #(.POLICY(POLICY)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .hit(hit), .vld(vld), .dirty(dirty), .mem_ack(mem_ack),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .evict_sel(evict_sel), .fill_en(fill_en),
        .commit_wr(commit_wr), .dirty_set(dirty_set)
    );

    // Processor read byte from the indexed line.
    assign cpu_rdata = rd_line[a_off*8 +: 8];

    // Memory port: victim line for write-back, else the requested line.
    always_comb begin
        if (evict_sel) begin
            mem_addr  = {vic_tag, a_idx};
            mem_be    = '1;
            mem_wdata = rd_line;
        end else begin
            mem_addr  = {a_tag, a_idx};
            mem_be    = lane_sel;
            mem_wdata = {LINE_BYTES{cpu_wdata}};
        end
    end

    // R12: the line address stays put while a request waits.
    a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

endmodule

// File: tb/tb_dmc_cache.sv
// Bench: one cache per write policy, each with its own memory model, its own
// behavioural reference (tags, dirty flags, architectural byte image) and
// its own access script. Counters are summed for the final report.
module tb_dmc_cache;
    import dmc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NPOL       = 3;
    localparam int WATCHDOG   = 150000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar p = 0; p < NPOL; p++) begin : g_pol
        localparam wpol_e POL = wpol_e'(p);

        logic        cpu_req = 1'b0;
        logic        cpu_we  = 1'b0;
        logic [9:0]  cpu_addr = '0;
        logic [7:0]  cpu_wdata = '0;
        logic [7:0]  cpu_rdata;
        logic        cpu_ready;
        logic        mem_req, mem_we;
        logic [6:0]  mem_addr;
        logic [7:0]  mem_be;
        logic [63:0] mem_wdata;
        logic [63:0] mem_rdata;
        logic        mem_ack;

        dmc_cache_top #(.POLICY(POL)) dut (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
            .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
            .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
            .mem_be(mem_be), .mem_wdata(mem_wdata),
            .mem_rdata(mem_rdata), .mem_ack(mem_ack)
        );

        logic [63:0] mem [128];
        logic [7:0]  arch [1024];
        logic        lg_we [64];
        logic [6:0]  lg_addr [64];
        int          lg_n;
        int          dly;
        bit          pend;
        logic [6:0]  paddr;
        logic        pwe;
        int cmp_s = 0, bad_s = 0, cmp_m = 0, bad_m = 0;
        bit done = 1'b0;

        function automatic logic [7:0] seed_byte(int a);
            return 8'((a * 37) ^ 8'h5C);
        endfunction

        function automatic logic [63:0] arch_blk(logic [6:0] b);
            logic [63:0] v;
            for (int k = 0; k < 8; k++) v[k*8 +: 8] = arch[{b, 3'(k)}];
            return v;
        endfunction

        // Memory model and per-clock port checks (R11, R12, R10 data).
        always @(negedge clk) begin
            if (!rst_n) begin
                for (int b = 0; b < 128; b++)
                    for (int k = 0; k < 8; k++)
                        mem[b][k*8 +: 8] = seed_byte(b*8 + k);
                mem_ack = 1'b0; mem_rdata = '0; lg_n = 0; dly = 0; pend = 1'b0;
            end else begin
                cmp_m++;
                if (mem_req && cpu_ready) begin
                    bad_m++;
                    $display("FAIL R11 pol%0d: cpu_ready actual 1 expected 0 while mem_req", p);
                end
                if (mem_ack) begin
                    mem_ack = 1'b0;
                end else if (mem_req) begin
                    if (!pend) begin
                        pend = 1'b1; paddr = mem_addr; pwe = mem_we;
                        dly = $urandom_range(0, 3);
                    end else begin
                        cmp_m++;
                        if (mem_addr !== paddr || mem_we !== pwe) begin
                            bad_m++;
                            $display("FAIL R12 pol%0d: addr/we actual %0h/%0b expected %0h/%0b",
                                     p, mem_addr, mem_we, paddr, pwe);
                        end
                    end
                    if (dly > 0) begin
                        dly--;
                    end else begin
                        mem_ack = 1'b1; pend = 1'b0;
                        lg_we[lg_n % 64] = mem_we; lg_addr[lg_n % 64] = mem_addr; lg_n++;
                        if (mem_we) begin
                            if (mem_be == 8'hFF) begin
                                cmp_m++;
                                if (mem_wdata !== arch_blk(mem_addr)) begin
                                    bad_m++;
                                    $display("FAIL R10 pol%0d: victim data actual %h expected %h",
                                             p, mem_wdata, arch_blk(mem_addr));
                                end
                            end
                            for (int k = 0; k < 8; k++)
                                if (mem_be[k]) mem[mem_addr][k*8 +: 8] = mem_wdata[k*8 +: 8];
                        end else begin
                            mem_rdata = mem[mem_addr];
                        end
                    end
                end
            end
        end

        bit         ref_v [8];
        bit         ref_d [8];
        logic [3:0] ref_t [8];
        int         lg_rd = 0;

        task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
            cmp_s++;
            if (!ok) begin
                bad_s++;
                $display("FAIL %s pol%0d %s: actual %0h expected %0h", rq, p, what, act, exp);
            end
        endtask

        // One access: predict traffic from the reference, run it, compare.
        task automatic access(bit we, logic [9:0] a, logic [7:0] d);
            logic [2:0]  ix = a[5:3];
            logic [3:0]  tg = a[9:6];
            logic [6:0]  blk = a[9:3];
            bit          hit = ref_v[ix] && (ref_t[ix] == tg);
            bit          evict = (POL == WP_BACK) && !hit && ref_v[ix] && ref_d[ix];
            bit          e_we [4];
            logic [6:0]  e_ad [4];
            int          n_exp = 0;
            int          waited = 0;
            string       rq;
            logic [63:0] snap = mem[blk];
            logic [7:0]  got;
            int          n_got;

            if (evict) begin e_we[n_exp] = 1; e_ad[n_exp] = {ref_t[ix], ix}; n_exp++; end
            if (!we) begin
                if (!hit) begin e_we[n_exp] = 0; e_ad[n_exp] = blk; n_exp++; end
                rq = hit ? "R3" : evict ? "R10" : ref_v[ix] ? "R5" : "R4";
            end else if (POL == WP_BACK) begin
                if (!hit) begin e_we[n_exp] = 0; e_ad[n_exp] = blk; n_exp++; end
                rq = hit ? "R9" : evict ? "R10" : "R4";
            end else begin
                if (!hit && POL == WP_THRU_ALLOC) begin e_we[n_exp] = 0; e_ad[n_exp] = blk; n_exp++; end
                e_we[n_exp] = 1; e_ad[n_exp] = blk; n_exp++;
                rq = hit ? "R6" : (POL == WP_THRU_ALLOC) ? "R8" : "R7";
            end

            @(negedge clk);
            cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
            #1;
            while (!cpu_ready) begin
                @(negedge clk); #1;
                waited++;
            end
            got = cpu_rdata;
            @(posedge clk);
            @(negedge clk);
            cpu_req = 1'b0; cpu_we = 1'b0;

            if (!we) chk(got == arch[a], rq, "read byte", 64'(got), 64'(arch[a]));
            else     arch[a] = d;

            n_got = lg_n - lg_rd;
            chk(n_got == n_exp, rq, "memory transaction count", 64'(n_got), 64'(n_exp));
            for (int i = 0; i < n_exp && i < n_got; i++) begin
                chk(lg_we[(lg_rd + i) % 64] == e_we[i], rq, "transaction direction",
                    64'(lg_we[(lg_rd + i) % 64]), 64'(e_we[i]));
                chk(lg_addr[(lg_rd + i) % 64] == e_ad[i], {rq, "/R2"}, "line address",
                    64'(lg_addr[(lg_rd + i) % 64]), 64'(e_ad[i]));
            end
            lg_rd = lg_n;
            if (n_exp == 0) chk(waited == 0, rq, "wait cycles", 64'(waited), 64'd0);

            if (POL != WP_BACK)
                chk(mem[blk] == arch_blk(blk), rq, "memory line", mem[blk], arch_blk(blk));
            else if (we && hit)
                chk(mem[blk] == snap, "R9", "memory line untouched", mem[blk], snap);

            // Reference update.
            if (!hit && !(we && POL == WP_THRU_NOALLOC)) begin
                ref_v[ix] = 1'b1; ref_t[ix] = tg; ref_d[ix] = 1'b0;
            end
            if (we && POL == WP_BACK) ref_d[ix] = 1'b1;
        endtask

        // Script: reset state, directed cases, then random traffic.
        initial begin
            for (int i = 0; i < 1024; i++) arch[i] = seed_byte(i);
            for (int i = 0; i < 8; i++) begin ref_v[i] = 0; ref_d[i] = 0; ref_t[i] = '0; end
            @(posedge rst_n);
            @(negedge clk);
            chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "ready/req after reset",
                {cpu_ready, mem_req}, 64'd0);
            access(0, {4'd1, 3'd2, 3'd3}, 8'h00);   // first access misses (R1, R4)
            chk(lg_n == 1, "R1", "fill count after first read", 64'(lg_n), 64'd1);
            access(0, {4'd1, 3'd2, 3'd5}, 8'h00);   // same line hits (R3)
            access(1, {4'd1, 3'd2, 3'd1}, 8'h5A);   // write hit (R6 / R9)
            access(0, {4'd1, 3'd2, 3'd1}, 8'h00);   // reads back 5A
            access(1, {4'd3, 3'd2, 3'd0}, 8'hC3);   // conflicting write miss (R7/R8/R10)
            access(0, {4'd1, 3'd2, 3'd1}, 8'h00);   // old line: hit only without allocation
            access(0, {4'd2, 3'd2, 3'd4}, 8'h00);   // clean victim, no write-back (R10, R5)
            access(0, {4'd0, 3'd7, 3'd7}, 8'h00);   // last index and offset (R2)
            for (int n = 0; n < 120; n++) begin
                logic [9:0] ra = {2'b00, 2'($urandom_range(0, 3)), 1'b0,
                                  2'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
                access($urandom_range(0, 9) < 4, ra, 8'($urandom()));
            end
            done = 1'b1;
        end
    end

    // Reset, watchdog and summary.
    initial begin
        int total_c, total_b;
        bit timeout = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                wait (g_pol[0].done && g_pol[1].done && g_pol[2].done);
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        total_c = g_pol[0].cmp_s + g_pol[0].cmp_m + g_pol[1].cmp_s + g_pol[1].cmp_m
                + g_pol[2].cmp_s + g_pol[2].cmp_m;
        total_b = g_pol[0].bad_s + g_pol[0].bad_m + g_pol[1].bad_s + g_pol[1].bad_m
                + g_pol[2].bad_s + g_pol[2].bad_m;
        if (timeout) begin
            total_c++; total_b++;
            $display("FAIL watchdog: run actual unfinished expected finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total_c, total_b);
        $finish;
    end

endmodule